// File: doc/BRIEF.md
# Compare-Match Timer with Forced Output Action

This block is an up-counter paired with one compare register. Each cycle in which the tick-enable input is high, the counter advances by one. When it counts into the compare value, the timer records a match. One clock later three things can happen:

- the compare flag is raised;
- the counter may be returned to zero;
- a programmed action is applied to a single output pin: hold, toggle, drive low or drive high.

An overflow flag records the counter wrapping from all-ones to zero. Each flag has its own interrupt enable.

Software reaches the block through a single-cycle write port. A selector code picks one of five targets:

- the control register;
- the counter;
- the compare register;
- a force strobe;
- a write-one-to-clear flag register.

The force strobe applies the programmed pin action immediately. It sets no flag and never clears the counter. This lets software move the pin without waiting for the count.

A match is defined only by counting. A write that leaves the counter equal to the compare value is not a match. A value written to the counter lands one clock after the write and overrides any tick in that clock.

Top module: `cmp_timer`

## Requirements
- R1: While reset is low and after it is released, count_o, compare_o, pin_o, both flags and both interrupt outputs are 0.
- R2: With tick high and no counter load or clear pending, count_o rises by one per clock and wraps from 0xFF to 0x00; with tick low it holds.
- R3: A write with wr_sel = 1 loads wr_data into the counter on the clock edge after the write edge, taking priority over any tick in that cycle.
- R4: A match happens only when a tick moves the counter onto the compare value; writing the counter (wr_sel = 1) or the compare register (wr_sel = 2) so that they become equal produces no match.
- R5: With control bit 0 (clear-on-match) set, the counter is 0x00 one edge after it reached the compare value, even with tick high; with the bit clear it keeps counting.
- R6: The compare flag is set on the edge after the counter reached the compare value.
- R7: Control bits 2:1 select the pin action applied on the edge after a match: 00 hold, 01 toggle, 10 drive low, 11 drive high.
- R8: A write with wr_sel = 3 and wr_data bit 0 set applies the bit 2:1 action to pin_o on the write edge. It neither sets the compare flag nor changes the counter, even with clear-on-match set.
- R9: The overflow flag is set on the edge where the counter wraps from 0xFF to 0x00.
- R10: A write with wr_sel = 4 clears the compare flag for wr_data bit 0 and the overflow flag for bit 1. A set in the same cycle wins over the clear.
- R11: cmp_irq_o is the compare flag gated by control bit 3, and ovf_irq_o is the overflow flag gated by control bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per clock while high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1 counter, 2 compare, 3 force, 4 flag clear |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current counter value |
| compare_o | output | 8 | Current compare value |
| pin_o | output | 1 | Compare output pin |
| cmp_flag_o | output | 1 | Compare match flag |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_irq_o | output | 1 | Compare interrupt request |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
Most internal faults show up at the ports within one or two clocks. A lost or stuck pending counter load shows as a wrong count_o on the clock after a counter write. A match register that fires early, late or from a write shows as pin_o, the compare flag or the counter clear moving one edge away from the expected one, or moving where no tick was applied. A force strobe wrongly routed into the match path shows at once as a set compare flag or a zeroed counter on the write edge.

// File: rtl/cmp_timer_pkg.sv
// Package: shared encodings for the compare-match timer.
// Assumes the control word fits in the low bits of the write data.
package cmp_timer_pkg;

    // Pin action applied on a match or a force strobe
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } pin_act_e;

    // Write target selector codes
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_CMP   = 3'd2,
        SEL_FORCE = 3'd3,
        SEL_FLAGS = 3'd4
    } wr_sel_e;

    // Control word: bit4 ovf irq en, bit3 cmp irq en, bits2:1 action, bit0 clear
    typedef struct packed {
        logic     ovf_ie;
        logic     cmp_ie;
        pin_act_e act;
        logic     clr_on_hit;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cmp_timer_count.sv
// Module: counter core with delayed load, match detection and wrap detection.
// Assumes: load_req is a one-cycle strobe; a match is flagged only when a tick
// moves the counter onto cmp_val; hit is registered, so its effects land
// one edge after the counter reaches the compare value.
module cmp_timer_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_req,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    input  logic         clr_on_hit,
    output logic [W-1:0] cnt,
    output logic         hit,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic         ld_pend;
    logic [W-1:0] ld_val_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] inc;
    logic         hit_q;
    logic         clear_now;
    logic         advance;

    // Decide this cycle's counter step
    always_comb begin
        clear_now = hit_q & clr_on_hit;
        advance   = tick & ~ld_pend & ~clear_now;
        inc       = cnt_q + ONE;
        wrap      = advance & (cnt_q == CNT_MAX);
    end

    // Hold a counter write for one clock before it lands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend  <= 1'b0;
            ld_val_q <= '0;
        end else begin
            ld_pend  <= load_req;
            if (load_req) ld_val_q <= load_val;
        end
    end

    // Counter register: load, then clear on match, then count
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (ld_pend)   cnt_q <= ld_val_q;
        else if (clear_now) cnt_q <= '0;
        else if (advance)   cnt_q <= inc;
    end

    // Match register: set when counting onto the compare value
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= advance && (inc == cmp_val);
    end

    assign cnt = cnt_q;
    assign hit = hit_q;

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick) && !$past(ld_pend) && !$past(hit_q && clr_on_hit))
        |-> (cnt_q == $past(cnt_q) + ONE));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(load_req, 2))
        |-> (cnt_q == $past(load_val, 2)));

    assert_hit_by_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && hit_q) |-> $past(tick));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hit_q) && $past(clr_on_hit) && !$past(ld_pend))
        |-> (cnt_q == '0));

endmodule

// File: rtl/cmp_timer_pin.sv
// Module: compare output pin; applies the programmed action when fired.
// Assumes: fire merges match and force in one cycle, so the action is applied once.
module cmp_timer_pin
    import cmp_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_act_e act,
    input  logic     fire,
    output logic     pin
);
    logic pin_q;

    // Pin register: resets low, follows the action code on fire
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else if (fire) begin
            case (act)
                ACT_TOGGLE: pin_q <= ~pin_q;
                ACT_LOW:    pin_q <= 1'b0;
                ACT_HIGH:   pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    assign pin = pin_q;

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(act) == ACT_NONE)) |-> $stable(pin_q));

    assert_drive_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fire) && ($past(act) == ACT_LOW)) |-> !pin_q);

    assert_drive_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fire) && ($past(act) == ACT_HIGH)) |-> pin_q);

endmodule

// File: rtl/cmp_timer_flags.sv
// Module: sticky event flags with write-one-to-clear and interrupt gating.
// Assumes: a set and a clear in the same cycle leave the flag set.
module cmp_timer_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        // Sticky flag: set wins over a simultaneous clear
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (set[i]) flag_q <= 1'b1;
            else if (clr[i]) flag_q <= 1'b0;
        end

        assign flag[i] = flag_q;
        assign irq[i]  = flag_q & ie[i];

        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(set[i])) |-> flag_q);

        assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(clr[i]) && !$past(set[i])) |-> !flag_q);
    end

endmodule

// File: rtl/cmp_timer.sv
// Module: top of the compare-match timer; holds control and compare registers,
// decodes the write port and connects the counter, pin and flag units.
// Assumes: W is at least CTRL_W, so the control word fits in wr_data.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic [W-1:0] compare_o,
    output logic         pin_o,
    output logic         cmp_flag_o,
    output logic         ovf_flag_o,
    output logic         cmp_irq_o,
    output logic         ovf_irq_o
);
    localparam int FLAG_CMP = 0;
    localparam int FLAG_OVF = 1;

    ctrl_t        ctrl_q;
    logic [W-1:0] cmp_q;
    logic         load_req;
    logic         force_stb;
    logic         flag_wr;
    logic         hit;
    logic         wrap;
    logic [1:0]   flag_set;
    logic [1:0]   flag_clr;
    logic [1:0]   flag_ie;
    logic [1:0]   flag_q;
    logic [1:0]   irq_q;

    // Decode write strobes per target
    always_comb begin
        load_req  = wr_en && (wr_sel == SEL_COUNT);
        force_stb = wr_en && (wr_sel == SEL_FORCE) && wr_data[0];
        flag_wr   = wr_en && (wr_sel == SEL_FLAGS);
    end

    // Control and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_sel == SEL_CMP)  cmp_q  <= wr_data;
        end
    end

    cmp_timer_count #(.W(W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_req   (load_req),
        .load_val   (wr_data),
        .cmp_val    (cmp_q),
        .clr_on_hit (ctrl_q.clr_on_hit),
        .cnt        (count_o),
        .hit        (hit),
        .wrap       (wrap)
    );

    cmp_timer_pin u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (ctrl_q.act),
        .fire  (hit | force_stb),
        .pin   (pin_o)
    );

    // Route flag events, clears and enables
    always_comb begin
        flag_set[FLAG_CMP] = hit;
        flag_set[FLAG_OVF] = wrap;
        flag_clr[FLAG_CMP] = flag_wr & wr_data[0];
        flag_clr[FLAG_OVF] = flag_wr & wr_data[1];
        flag_ie[FLAG_CMP]  = ctrl_q.cmp_ie;
        flag_ie[FLAG_OVF]  = ctrl_q.ovf_ie;
    end

    cmp_timer_flags #(.N(2)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .ie    (flag_ie),
        .flag  (flag_q),
        .irq   (irq_q)
    );

    assign compare_o  = cmp_q;
    assign cmp_flag_o = flag_q[FLAG_CMP];
    assign ovf_flag_o = flag_q[FLAG_OVF];
    assign cmp_irq_o  = irq_q[FLAG_CMP];
    assign ovf_irq_o  = irq_q[FLAG_OVF];

    assert_cmp_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hit)) |-> cmp_flag_o);

    assert_force_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(force_stb) && !$past(hit) && !$past(cmp_flag_o))
        |-> !cmp_flag_o);

    assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wrap)) |-> (ovf_flag_o && (count_o == '0)));

endmodule

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       wr_en;
    logic [2:0] wr_sel;
    logic [7:0] wr_data;
    logic [7:0] count_o;
    logic [7:0] compare_o;
    logic       pin_o;
    logic       cmp_flag_o;
    logic       ovf_flag_o;
    logic       cmp_irq_o;
    logic       ovf_irq_o;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    cmp_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .count_o    (count_o),
        .compare_o  (compare_o),
        .pin_o      (pin_o),
        .cmp_flag_o (cmp_flag_o),
        .ovf_flag_o (ovf_flag_o),
        .cmp_irq_o  (cmp_irq_o),
        .ovf_irq_o  (ovf_irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge passes; returns at the next falling edge
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) cyc();
        chk("R1 count in reset", count_o, 8'h00);
        tick = 1'b0;
        rst_n = 1'b1;
        cyc();
        chk("R1 count", count_o, 8'h00);
        chk("R1 compare", compare_o, 8'h00);
        chk("R1 pin", {7'b0, pin_o}, 8'h00);
        chk("R1 flags", {6'b0, ovf_flag_o, cmp_flag_o}, 8'h00);
        chk("R1 irqs", {6'b0, ovf_irq_o, cmp_irq_o}, 8'h00);
    endtask

    task automatic t_count_load();
        wr(3'd1, 8'h05);
        chk("R3 load not yet landed", count_o, 8'h00);
        cyc();
        chk("R3 load landed", count_o, 8'h05);
        tick = 1'b1;
        repeat (3) cyc();
        chk("R2 three ticks", count_o, 8'h08);
        wr(3'd1, 8'h40);
        chk("R2 tick on write edge", count_o, 8'h09);
        cyc();
        chk("R3 load beats tick", count_o, 8'h40);
        cyc();
        chk("R2 count after load", count_o, 8'h41);
        tick = 1'b0;
        cyc();
        chk("R2 hold without tick", count_o, 8'h41);
    endtask

    task automatic t_overflow();
        wr(3'd2, 8'h80);
        wr(3'd1, 8'hFE);
        cyc();
        tick = 1'b1;
        cyc();
        chk("R2 reach max", count_o, 8'hFF);
        chk("R9 no flag before wrap", {7'b0, ovf_flag_o}, 8'h00);
        cyc();
        tick = 1'b0;
        chk("R2 wrap", count_o, 8'h00);
        chk("R9 flag on wrap", {7'b0, ovf_flag_o}, 8'h01);
        chk("R11 ovf irq masked", {7'b0, ovf_irq_o}, 8'h00);
        wr(3'd0, 8'h10);
        chk("R11 ovf irq enabled", {7'b0, ovf_irq_o}, 8'h01);
        wr(3'd4, 8'h02);
        chk("R10 ovf cleared", {7'b0, ovf_flag_o}, 8'h00);
        chk("R11 ovf irq follows", {7'b0, ovf_irq_o}, 8'h00);
    endtask

    task automatic t_match_clear();
        wr(3'd0, 8'h0B);
        wr(3'd2, 8'h10);
        wr(3'd1, 8'h0E);
        cyc();
        tick = 1'b1;
        cyc();
        cyc();
        chk("R4 reach compare", count_o, 8'h10);
        chk("R6 flag not yet", {7'b0, cmp_flag_o}, 8'h00);
        chk("R7 pin not yet", {7'b0, pin_o}, 8'h00);
        cyc();
        tick = 1'b0;
        chk("R5 cleared after match", count_o, 8'h00);
        chk("R6 flag set", {7'b0, cmp_flag_o}, 8'h01);
        chk("R7 toggle", {7'b0, pin_o}, 8'h01);
        chk("R11 cmp irq", {7'b0, cmp_irq_o}, 8'h01);
        wr(3'd4, 8'h01);
        chk("R10 cmp cleared", {7'b0, cmp_flag_o}, 8'h00);
    endtask

    task automatic t_match_noclear();
        wr(3'd0, 8'h04);
        wr(3'd1, 8'h0F);
        cyc();
        tick = 1'b1;
        cyc();
        cyc();
        tick = 1'b0;
        chk("R5 keeps counting", count_o, 8'h11);
        chk("R6 flag set", {7'b0, cmp_flag_o}, 8'h01);
        chk("R7 drive low", {7'b0, pin_o}, 8'h00);
        chk("R11 cmp irq masked", {7'b0, cmp_irq_o}, 8'h00);
        wr(3'd4, 8'h01);
    endtask

    task automatic t_write_equal();
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h10);
        cyc();
        cyc();
        chk("R4 counter write equal", {7'b0, cmp_flag_o}, 8'h00);
        chk("R4 counter kept", count_o, 8'h10);
        wr(3'd1, 8'h22);
        cyc();
        wr(3'd2, 8'h22);
        cyc();
        cyc();
        chk("R4 compare write equal", {7'b0, cmp_flag_o}, 8'h00);
        chk("R4 no clear", count_o, 8'h22);
        chk("R4 pin untouched", {7'b0, pin_o}, 8'h00);
    endtask

    task automatic t_force();
        wr(3'd3, 8'h01);
        chk("R8 force toggles", {7'b0, pin_o}, 8'h01);
        chk("R8 no flag", {7'b0, cmp_flag_o}, 8'h00);
        chk("R8 no clear", count_o, 8'h22);
        cyc();
        chk("R8 no flag later", {7'b0, cmp_flag_o}, 8'h00);
        chk("R8 no clear later", count_o, 8'h22);
        wr(3'd3, 8'h01);
        chk("R8 force toggles back", {7'b0, pin_o}, 8'h00);
        wr(3'd3, 8'h00);
        chk("R8 bit0 clear no effect", {7'b0, pin_o}, 8'h00);
        wr(3'd0, 8'h07);
        wr(3'd3, 8'h01);
        chk("R7 force drive high", {7'b0, pin_o}, 8'h01);
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h01);
        chk("R7 action none holds", {7'b0, pin_o}, 8'h01);
    endtask

    task automatic t_set_wins();
        wr(3'd2, 8'h30);
        wr(3'd1, 8'h2F);
        cyc();
        tick = 1'b1;
        cyc();
        chk("R4 reach compare", count_o, 8'h30);
        wr(3'd4, 8'h01);
        tick = 1'b0;
        chk("R10 set beats clear", {7'b0, cmp_flag_o}, 8'h01);
        chk("R5 clear beats tick", count_o, 8'h00);
        chk("R7 hold on match", {7'b0, pin_o}, 8'h01);
        wr(3'd4, 8'h01);
        chk("R10 later clear", {7'b0, cmp_flag_o}, 8'h00);
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_count_load();
        t_overflow();
        t_match_clear();
        t_match_noclear();
        t_write_equal();
        t_force();
        t_set_wins();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule